// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Multiplexed Display

This block keeps a 24-hour time of day in packed BCD, from 00:00:00 up to 23:59:59 and back to 00:00:00. A divider on the system clock issues a one-cycle enable once per second. That enable drives three chained counters: seconds, then minutes, then hours. Each stage passes a carry to the next in the same cycle in which it wraps. All state sits in the system clock domain. No derived clocks are used.

A pause input stops the divider. The divider keeps its phase while paused, so the second that was under way resumes where it stopped. A preset strobe loads all three fields at once from a 24-bit BCD word in the form hours, minutes, seconds. Any nibble that is not legal for its field is loaded as 0. An asynchronous active-low clear sets the time to zero.

A scanner state machine shows the six digits in turn on an active-low seven-segment bus. It drives one active-low select line per digit and holds each digit for a set number of cycles (about 1 ms at 50 MHz).

- The scanner has six states: POS_HRS_T, POS_HRS_U, POS_MIN_T, POS_MIN_U, POS_SEC_T and POS_SEC_U.
- Its one transition, "advance", moves to the next state in that list when the dwell counter expires.
- From POS_SEC_U, "advance" returns to POS_HRS_T.

Top module: `bcd_clock_top`

## Requirements
- R1: After reset the time reads 00:00:00 and the scanner selects the tens-of-hours digit (dig_n = 6'b111110).
- R2: When pause is low, the seconds advance by one every TICK_DIV system clock cycles.
- R3: A units nibble of 9 returns to 0 and increments the tens nibble. Seconds and minutes wrap from 59 to 00 and carry into the next field in the same cycle.
- R4: Hours wrap from 23 to 00 and never show 24, so 23:59:59 is followed by 00:00:00.
- R5: When pause is high, the time does not change and the divider holds its phase. After release, the next second arrives after the cycles that were still left.
- R6: On a clock edge with load high, the time becomes the preset word {hours, minutes, seconds} in BCD (bits 23..16, 15..8, 7..0). This happens whether or not pause is high, and it replaces a tick on the same edge. The divider is not disturbed by the load.
- R7: Preset nibbles outside the legal range load as 0. Tens of seconds and tens of minutes above 5 load as 0, tens of hours above 2 load as 0, and any units nibble above 9 loads as 0. Units of hours above 3 load as 0 when the tens of hours is 2.
- R8: dig_n is one-cold. Bit k selects the k-th digit in the order tens of hours, hours, tens of minutes, minutes, tens of seconds, seconds. Each digit stays selected for SCAN_DIV cycles, and the order repeats.
- R9: seg_n carries the active-low segment code of the selected digit, with bit 7 as an always-off point. The codes are 0=C0, 1=F9, 2=A4, 3=B0, 4=99, 5=92, 6=82, 7=F8, 8=80, 9=90 (hex).
- R10: Clear is asynchronous. While rst_n is low, with no clock edge, seg_n = 8'hC0 and dig_n = 6'b111110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| pause | input | 1 | High stops the time and holds the divider phase |
| load | input | 1 | Preset strobe, sampled on the clock edge |
| load_bcd | input | 24 | Preset time: hours [23:16], minutes [15:8], seconds [7:0], packed BCD |
| seg_n | output | 8 | Active-low segment code, bit 7 is the point |
| dig_n | output | 6 | Active-low one-cold digit select |

## Verification
The assertions assume that pause, load and load_bcd change only away from the rising edge and are stable at each edge. They also assume rst_n is released between edges. The bench meets both assumptions by driving every input on the falling edge and releasing clear there as well.

The range assertion on each stage assumes that only the clamped preset path can bring a value into the counter. The bench applies illegal preset words on purpose to exercise that path. The bench reads the time only while paused, so that each six-digit scan sees one frozen value.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

    typedef enum logic [2:0] {
        POS_HRS_T,
        POS_HRS_U,
        POS_MIN_T,
        POS_MIN_U,
        POS_SEC_T,
        POS_SEC_U
    } scan_pos_e;

    // active-low segment pattern, bit 7 = point (kept dark)
    function automatic logic [7:0] seg_code(input logic [3:0] d);
        logic [7:0] s;
        unique case (d)
            4'd0:    s = 8'hC0;
            4'd1:    s = 8'hF9;
            4'd2:    s = 8'hA4;
            4'd3:    s = 8'hB0;
            4'd4:    s = 8'h99;
            4'd5:    s = 8'h92;
            4'd6:    s = 8'h82;
            4'd7:    s = 8'hF8;
            4'd8:    s = 8'h80;
            4'd9:    s = 8'h90;
            default: s = 8'hFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    // two ticks never fall on adjacent cycles when the divide is above one
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && TICK_DIV > 1) |=> !tick);

endmodule

// File: rtl/bcd_stage.sv
module bcd_stage #(
    parameter int MAX_TENS  = 5,
    parameter int MAX_UNITS = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] val,
    output logic       carry_out
);
    localparam logic [3:0] TMAX = 4'(MAX_TENS);
    localparam logic [3:0] UMAX = 4'(MAX_UNITS);

    logic       at_top;
    logic [3:0] ld_t, ld_u;

    assign at_top    = (val == {TMAX, UMAX});
    assign carry_out = inc && at_top;

    always_comb begin
        ld_t = (load_val[7:4] > TMAX) ? 4'd0 : load_val[7:4];
        if (load_val[3:0] > 4'd9 || (ld_t == TMAX && load_val[3:0] > UMAX))
            ld_u = 4'd0;
        else
            ld_u = load_val[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= 8'h00;
        else if (load)
            val <= {ld_t, ld_u};
        else if (inc) begin
            if (at_top)
                val <= 8'h00;
            else if (val[3:0] == 4'd9)
                val <= {val[7:4] + 4'd1, 4'd0};
            else
                val <= {val[7:4], val[3:0] + 4'd1};
        end
    end

    p_legal_bcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        val[3:0] <= 4'd9 && val[7:4] <= TMAX && !(val[7:4] == TMAX && val[3:0] > UMAX));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_out && !load) |=> val == 8'h00);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(val));

endmodule

// File: rtl/digit_scan.sv
module digit_scan
    import bcd_clock_pkg::*;
#(
    parameter int SCAN_DIV = 50_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] time_bcd,
    output logic [7:0]  seg_n,
    output logic [5:0]  dig_n
);
    localparam int SW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [SW-1:0] DWELL_LAST = SW'(SCAN_DIV - 1);

    scan_pos_e    pos, pos_nxt;
    logic [SW-1:0] dwell;
    logic          advance;
    logic [3:0]    nib;

    assign advance = (dwell == DWELL_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos   <= POS_HRS_T;
            dwell <= '0;
        end else begin
            pos   <= pos_nxt;
            dwell <= advance ? '0 : dwell + 1'b1;
        end
    end

    always_comb begin
        pos_nxt = pos;
        if (advance) begin
            unique case (pos)
                POS_HRS_T: pos_nxt = POS_HRS_U;
                POS_HRS_U: pos_nxt = POS_MIN_T;
                POS_MIN_T: pos_nxt = POS_MIN_U;
                POS_MIN_U: pos_nxt = POS_SEC_T;
                POS_SEC_T: pos_nxt = POS_SEC_U;
                POS_SEC_U: pos_nxt = POS_HRS_T;
                default:   pos_nxt = POS_HRS_T;
            endcase
        end
    end

    always_comb begin
        unique case (pos)
            POS_HRS_T: begin nib = time_bcd[23:20]; dig_n = 6'b111110; end
            POS_HRS_U: begin nib = time_bcd[19:16]; dig_n = 6'b111101; end
            POS_MIN_T: begin nib = time_bcd[15:12]; dig_n = 6'b111011; end
            POS_MIN_U: begin nib = time_bcd[11:8];  dig_n = 6'b110111; end
            POS_SEC_T: begin nib = time_bcd[7:4];   dig_n = 6'b101111; end
            POS_SEC_U: begin nib = time_bcd[3:0];   dig_n = 6'b011111; end
            default:   begin nib = 4'hF;            dig_n = 6'b111111; end
        endcase
        seg_n = seg_code(nib);
    end

    p_one_cold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_n) == 1);

    p_seg_lit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_n[7] && seg_n != 8'hFF);

endmodule

// File: rtl/bcd_clock_top.sv
module bcd_clock_top #(
    parameter int TICK_DIV = 50_000_000,
    parameter int SCAN_DIV = 50_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pause,
    input  logic        load,
    input  logic [23:0] load_bcd,
    output logic [7:0]  seg_n,
    output logic [5:0]  dig_n
);
    logic        tick;
    logic        sec_co, min_co, day_wrap;
    logic [7:0]  sec_v, min_v, hrs_v;
    logic [23:0] time_bcd;

    tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(!pause), .tick(tick)
    );

    bcd_stage #(.MAX_TENS(5), .MAX_UNITS(9)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(tick), .load(load),
        .load_val(load_bcd[7:0]), .val(sec_v), .carry_out(sec_co)
    );

    bcd_stage #(.MAX_TENS(5), .MAX_UNITS(9)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_co), .load(load),
        .load_val(load_bcd[15:8]), .val(min_v), .carry_out(min_co)
    );

    bcd_stage #(.MAX_TENS(2), .MAX_UNITS(3)) u_hrs (
        .clk(clk), .rst_n(rst_n), .inc(min_co), .load(load),
        .load_val(load_bcd[23:16]), .val(hrs_v), .carry_out(day_wrap)
    );

    assign time_bcd = {hrs_v, min_v, sec_v};

    digit_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk(clk), .rst_n(rst_n), .time_bcd(time_bcd),
        .seg_n(seg_n), .dig_n(dig_n)
    );

    p_pause_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !load) |=> $stable(time_bcd));

    p_midnight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_wrap && !load) |=> time_bcd == 24'h000000);

endmodule

// File: tb/bcd_clock_top_test.sv
module bcd_clock_top_test;

    localparam int TICK_DIV = 16;
    localparam int SCAN_DIV = 2;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause = 1'b1;
    logic        load = 1'b0;
    logic [23:0] load_bcd = 24'h0;
    logic [7:0]  seg_n;
    logic [5:0]  dig_n;

    int checks = 0;
    int errors = 0;
    int phase = 0;
    int cycles = 0;
    bit done = 0;

    bcd_clock_top #(.TICK_DIV(TICK_DIV), .SCAN_DIV(SCAN_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .pause(pause), .load(load),
        .load_bcd(load_bcd), .seg_n(seg_n), .dig_n(dig_n)
    );

    always #4 clk = ~clk;

    // preset, ticks to run, expected time; requirement noted per row
    localparam logic [23:0] V_PRE [NV] = '{
        24'h000000,  // R2
        24'h000009,  // R3
        24'h000059,  // R3
        24'h005959,  // R3
        24'h095959,  // R3
        24'h235959,  // R4
        24'h235958,  // R4
        24'h123456,  // R2
        24'h195959,  // R3
        24'h29635F,  // R7
        24'h3A9CB5   // R7
    };
    localparam int V_N [NV] = '{1, 1, 1, 1, 1, 1, 3, 5, 2, 0, 0};
    localparam logic [23:0] V_EXP [NV] = '{
        24'h000001, 24'h000010, 24'h000100, 24'h010000, 24'h100000,
        24'h000000, 24'h000001, 24'h123501, 24'h200001, 24'h200350,
        24'h000005
    };
    localparam int V_REQ [NV] = '{2, 3, 3, 3, 3, 4, 4, 2, 3, 7, 7};

    function automatic logic [3:0] seg_to_digit(input logic [7:0] s);
        case (s)
            8'hC0: return 4'd0;  8'hF9: return 4'd1;
            8'hA4: return 4'd2;  8'hB0: return 4'd3;
            8'h99: return 4'd4;  8'h92: return 4'd5;
            8'h82: return 4'd6;  8'hF8: return 4'd7;
            8'h80: return 4'd8;  8'h90: return 4'd9;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [5:0] sel(input int k);
        return ~(6'b1 << k);
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic l, input logic [23:0] d);
        @(negedge clk);
        pause = p; load = l; load_bcd = d;
        @(posedge clk);
        if (!p) begin
            phase++;
            if (phase == TICK_DIV) phase = 0;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        pause = 1'b1; load = 1'b0;
    endtask

    task automatic preset(input logic [23:0] d);
        step(1'b1, 1'b1, d);
        idle();
    endtask

    task automatic run_ticks(input int n);
        int left = n;
        while (left > 0) begin
            step(1'b0, 1'b0, 24'h0);
            if (phase == 0) left--;
        end
        idle();
    endtask

    task automatic run_edges(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 24'h0);
        idle();
    endtask

    task automatic read_segs(output logic [47:0] segs);
        for (int k = 0; k < 6; k++) begin
            do @(negedge clk); while (dig_n !== sel(k));
            segs[47-8*k -: 8] = seg_n;
        end
    endtask

    task automatic read_time(output logic [23:0] t);
        logic [47:0] s;
        read_segs(s);
        for (int k = 0; k < 6; k++) t[23-4*k -: 4] = seg_to_digit(s[47-8*k -: 8]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual %0d expected below 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [23:0] t;
        logic [47:0] s;
        int cnt;
        logic [5:0] cur;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 select after reset", {42'h0, dig_n}, {42'h0, 6'b111110});
        read_time(t);
        check("R1 time after reset", {24'h0, t}, {24'h0, 24'h000000});

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            preset(V_PRE[i]);
            run_ticks(V_N[i]);
            read_time(t);
            check($sformatf("R%0d vector %0d", V_REQ[i], i), {24'h0, t}, {24'h0, V_EXP[i]});
        end

        // R2: seconds step only after the full divide
        preset(24'h080000);
        run_edges(TICK_DIV - 1);
        read_time(t);
        check("R2 no tick before divide", {24'h0, t}, {24'h0, 24'h080000});
        run_edges(1);
        read_time(t);
        check("R2 tick at divide", {24'h0, t}, {24'h0, 24'h080001});

        // R5: pause freezes time and divider phase
        run_edges(5);
        repeat (40) @(negedge clk);
        read_time(t);
        check("R5 frozen while paused", {24'h0, t}, {24'h0, 24'h080001});
        run_edges(TICK_DIV - 6);
        read_time(t);
        check("R5 phase kept, not yet", {24'h0, t}, {24'h0, 24'h080001});
        run_edges(1);
        read_time(t);
        check("R5 phase kept, tick", {24'h0, t}, {24'h0, 24'h080002});

        // R6: load wins over a tick on the same edge
        run_edges(TICK_DIV - 1 - phase);
        step(1'b0, 1'b1, 24'h174459);
        idle();
        read_time(t);
        check("R6 load beats tick", {24'h0, t}, {24'h0, 24'h174459});
        run_edges(TICK_DIV - 1);
        read_time(t);
        check("R6 divider wrapped at load edge", {24'h0, t}, {24'h0, 24'h174459});
        run_edges(1);
        read_time(t);
        check("R6 next tick after load", {24'h0, t}, {24'h0, 24'h174500});

        // R7: hours units above 3 with tens 2
        preset(24'h240000);
        read_time(t);
        check("R7 hours 24 clamps units", {24'h0, t}, {24'h0, 24'h200000});

        // R9: raw segment codes
        preset(24'h195807);
        read_segs(s);
        check("R9 codes 1 9 5 8 0 7", s, 48'hF9_90_92_80_C0_F8);
        preset(24'h063429);
        read_segs(s);
        check("R9 codes 0 6 3 4 2 9", s, 48'hC0_82_B0_99_A4_90);

        // R8: order and dwell
        do @(negedge clk); while (dig_n !== sel(5));
        do @(negedge clk); while (dig_n !== sel(0));
        cur = sel(0);
        cnt = 1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            while (dig_n === cur) begin
                cnt++;
                @(negedge clk);
            end
            check("R8 dwell", {16'h0, 32'(cnt)}, {16'h0, 32'(SCAN_DIV)});
            check("R8 order", {42'h0, dig_n}, {42'h0, sel(k % 6)});
            cur = dig_n;
            cnt = 1;
        end

        // R10: asynchronous clear
        preset(24'h123456);
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        check("R10 clear without edge", {34'h0, seg_n, dig_n}, {34'h0, 8'hC0, 6'b111110});
        @(negedge clk);
        rst_n = 1'b1;
        phase = 0;
        read_time(t);
        check("R10 time after clear", {24'h0, t}, {24'h0, 24'h000000});

        finish_run();
    end

endmodule